// File: doc/BRIEF.md
# Invalidation-Based Dirty Line Tracker

This block watches individual cache lines for writes by other agents. It runs as a coherence agent beside the last-level cache, and it keeps only tags and a coherence state for each entry. It never holds line data. To start watching a line address, the block sends a read-shared request. Only when the grant comes back does it install the tag as a shared entry.

After that, any agent that wants to write the line must invalidate every shared copy. If an incoming invalidation matches a tracked shared entry, the block does two things: it drops the entry and queues the line address in a dirty-address FIFO, which a consumer drains. Each arming therefore catches one write at most. To catch the next write, the line has to be armed again, which sends a fresh read-shared request.

Tracking is driven entirely by arm commands, so no translation tables and no operating-system setup are needed. The tag store is direct-mapped. The low bits of the line address select the slot, and the remaining bits are kept as the tag.

Top module: `dirtyLineTracker`

## Requirements
- R1: When an arm command for an untracked line is accepted, `rdShReq` is high for exactly one cycle in the next cycle, with `rdShAddr` equal to the armed line address. `armReady` stays low from that cycle until the cycle after the grant.
- R2: A line only becomes tracked on the clock edge where `shGrant` is sampled while a request is outstanding. An invalidation of that line accepted before the grant produces no dirty record.
- R3: An accepted invalidation whose address matches a valid shared entry does three things: it pushes the full line address into the dirty FIFO, clears the entry, and makes `dirtyValid` high with that address at the head in the next cycle. A second invalidation of the same line produces no further record.
- R4: After a line has been invalidated, arming it again sends a new read-shared request. Once granted, the line is tracked again.
- R5: An arm command for a line that is already tracked is accepted and then ignored. No `rdShReq` follows, and `armReady` stays high.
- R6: An invalidation that misses, or that selects an invalid entry, produces no dirty record.
- R7: `invAck` is high for one cycle, exactly one cycle after each accepted invalidation (`invValid` and `invReady` high at a clock edge), whether it hit or not. `invAck` is never high otherwise.
- R8: While the FIFO holds FIFO_DEPTH records, `dirtyFull` is high and `invReady` is low. The pending invalidation waits and is not dropped. Records leave the FIFO in the order they arrived, and `dirtyPop` removes the head when `dirtyValid` is high.
- R9: The store has 2^INDEX_W slots (default 256), and each slot is indexed by the low INDEX_W address bits. When a line is armed into a slot held by a different tag, the old tag is replaced without notice, so a later invalidation of the old line misses.
- R10: After reset, no entry is valid and the FIFO is empty. `armReady` and `invReady` are high, and `rdShReq`, `invAck`, `dirtyValid` and `dirtyFull` are low.
- R11: A `shGrant` that arrives while no request is outstanding has no effect on the tag store.
- R12: An invalidation and a grant can land on the same slot in the same cycle. When they do, the invalidation is judged against the slot contents from before the grant, and the granted tag is then installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armValid | input | 1 | Arm command present |
| armAddr | input | LINE_W | Line address to arm |
| armReady | output | 1 | No read-shared request outstanding; arm may be taken |
| rdShReq | output | 1 | One-cycle read-shared request |
| rdShAddr | output | LINE_W | Line address of the request |
| shGrant | input | 1 | Read permission granted for the outstanding request |
| invValid | input | 1 | Invalidation present |
| invAddr | input | LINE_W | Line address being invalidated |
| invReady | output | 1 | Invalidation can be accepted (FIFO not full) |
| invAck | output | 1 | Acknowledge, one cycle after acceptance |
| dirtyValid | output | 1 | FIFO holds at least one record |
| dirtyAddr | output | LINE_W | Oldest dirty line address |
| dirtyPop | input | 1 | Consumer removes the head record |
| dirtyFull | output | 1 | FIFO full |

## Verification
The following rules are checked by assertions on every cycle:
- Each request follows an accepted arm, and arming is blocked while a request is outstanding.
- The acknowledge comes exactly one cycle after each accepted invalidation.
- The FIFO never overflows or underflows.
- A cleared or installed slot reads back as invalid or as shared with the right tag.

Some behaviours can only be shown by the bench's scenarios, run against a behavioural reference model:
- the one-write-per-arming rule and re-arming;
- ignored duplicate arms and stray grants;
- direct-mapped replacement;
- backpressure without loss and the FIFO's ordering;
- the case where a grant and an invalidation hit the same slot in the same cycle.

// File: rtl/dirtyTrkPkg.sv
package dirtyTrkPkg;

  typedef enum logic {
    LINE_INVALID = 1'b0,
    LINE_SHARED  = 1'b1
  } lineState_e;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_WAIT = 1'b1
  } ctlState_e;

  typedef struct packed {
    logic loadPending;
    logic install;
    logic clearHit;
    logic pushDirty;
    logic popDirty;
  } trkStrobes_t;

endpackage

// File: rtl/dirtyFifo.sv
module dirtyFifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             notEmpty,
  output logic [WIDTH-1:0] headData,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign notEmpty = (count != '0);
  assign full     = (count == DEPTH_CNT);
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> notEmpty);

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_CNT);

endmodule

// File: rtl/trkDatapath.sv
module trkDatapath
  import dirtyTrkPkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int INDEX_W    = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trkStrobes_t       strb,
  input  logic [LINE_W-1:0] armAddr,
  input  logic [LINE_W-1:0] invAddr,
  output logic              armHit,
  output logic              invHit,
  output logic [LINE_W-1:0] pendAddr,
  output logic              fifoNotEmpty,
  output logic [LINE_W-1:0] fifoHead,
  output logic              fifoFull
);
  localparam int TAG_W   = LINE_W - INDEX_W;
  localparam int ENTRIES = 1 << INDEX_W;

  lineState_e             lineState [ENTRIES];
  logic       [TAG_W-1:0] lineTag   [ENTRIES];

  logic [INDEX_W-1:0] armIdx, invIdx, pendIdx;
  logic [TAG_W-1:0]   armTag, invTag, pendTag;

  assign armIdx  = armAddr[INDEX_W-1:0];
  assign armTag  = armAddr[LINE_W-1:INDEX_W];
  assign invIdx  = invAddr[INDEX_W-1:0];
  assign invTag  = invAddr[LINE_W-1:INDEX_W];
  assign pendIdx = pendAddr[INDEX_W-1:0];
  assign pendTag = pendAddr[LINE_W-1:INDEX_W];

  // Lookups see the store as it stood at the start of the cycle.
  assign armHit = (lineState[armIdx] == LINE_SHARED) && (lineTag[armIdx] == armTag);
  assign invHit = (lineState[invIdx] == LINE_SHARED) && (lineTag[invIdx] == invTag);

  always_ff @(posedge clk) begin
    if (!rstN)                 pendAddr <= '0;
    else if (strb.loadPending) pendAddr <= armAddr;
  end

  // One state flop and tag register per slot; an install on the same slot
  // as a clear takes effect after it.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic setHere, clrHere;
    assign setHere = strb.install  && (pendIdx == INDEX_W'(g));
    assign clrHere = strb.clearHit && (invIdx  == INDEX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)        lineState[g] <= LINE_INVALID;
      else if (setHere) lineState[g] <= LINE_SHARED;
      else if (clrHere) lineState[g] <= LINE_INVALID;
    end

    always_ff @(posedge clk) begin
      if (setHere) lineTag[g] <= pendTag;
    end
  end

  dirtyFifo #(
    .WIDTH (LINE_W),
    .DEPTH (FIFO_DEPTH)
  ) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strb.pushDirty),
    .pushData (invAddr),
    .pop      (strb.popDirty),
    .notEmpty (fifoNotEmpty),
    .headData (fifoHead),
    .full     (fifoFull)
  );

  // R3
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearHit && !(strb.install && (pendIdx == invIdx)))
      |=> (lineState[$past(invIdx)] == LINE_INVALID));

  // R2
  install_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.install |=> (lineState[$past(pendIdx)] == LINE_SHARED)
                     && (lineTag[$past(pendIdx)] == $past(pendTag)));

endmodule

// File: rtl/trkControl.sv
module trkControl
  import dirtyTrkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armValid,
  input  logic        armHit,
  input  logic        shGrant,
  input  logic        invValid,
  input  logic        invHit,
  input  logic        fifoFull,
  input  logic        fifoNotEmpty,
  input  logic        dirtyPop,
  output trkStrobes_t strb,
  output logic        armReady,
  output logic        rdShReq,
  output logic        invReady,
  output logic        invAck
);
  ctlState_e state, stateNext;
  logic armAccept, invAccept, grantAccept;

  assign armReady    = (state == CTL_IDLE);
  assign armAccept   = armValid && armReady;
  assign invReady    = !fifoFull;
  assign invAccept   = invValid && invReady;
  assign grantAccept = shGrant && (state == CTL_WAIT);

  always_comb begin
    strb             = '0;
    strb.loadPending = armAccept && !armHit;
    strb.install     = grantAccept;
    strb.clearHit    = invAccept && invHit;
    strb.pushDirty   = invAccept && invHit;
    strb.popDirty    = dirtyPop && fifoNotEmpty;
  end

  always_comb begin
    stateNext = state;
    case (state)
      CTL_IDLE: if (strb.loadPending) stateNext = CTL_WAIT;
      CTL_WAIT: if (grantAccept)      stateNext = CTL_IDLE;
      default:                        stateNext = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= CTL_IDLE;
      rdShReq <= 1'b0;
      invAck  <= 1'b0;
    end else begin
      state   <= stateNext;
      rdShReq <= strb.loadPending;
      invAck  <= invAccept;
    end
  end

  // R1
  req_after_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdShReq |-> $past(armValid && armReady));

  // R1
  arm_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdShReq |-> !armReady);

  // R5
  tracked_arm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armValid && armReady && armHit) |=> !rdShReq);

  // R7
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invReady) |=> invAck);

  // R7
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    invAck |-> $past(invValid && invReady));

endmodule

// File: rtl/dirtyLineTracker.sv
module dirtyLineTracker
  import dirtyTrkPkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int INDEX_W    = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armValid,
  input  logic [LINE_W-1:0] armAddr,
  output logic              armReady,
  output logic              rdShReq,
  output logic [LINE_W-1:0] rdShAddr,
  input  logic              shGrant,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invAddr,
  output logic              invReady,
  output logic              invAck,
  output logic              dirtyValid,
  output logic [LINE_W-1:0] dirtyAddr,
  input  logic              dirtyPop,
  output logic              dirtyFull
);
  trkStrobes_t strb;
  logic armHit, invHit;

  trkControl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .armValid     (armValid),
    .armHit       (armHit),
    .shGrant      (shGrant),
    .invValid     (invValid),
    .invHit       (invHit),
    .fifoFull     (dirtyFull),
    .fifoNotEmpty (dirtyValid),
    .dirtyPop     (dirtyPop),
    .strb         (strb),
    .armReady     (armReady),
    .rdShReq      (rdShReq),
    .invReady     (invReady),
    .invAck       (invAck)
  );

  trkDatapath #(
    .LINE_W     (LINE_W),
    .INDEX_W    (INDEX_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .armAddr      (armAddr),
    .invAddr      (invAddr),
    .armHit       (armHit),
    .invHit       (invHit),
    .pendAddr     (rdShAddr),
    .fifoNotEmpty (dirtyValid),
    .fifoHead     (dirtyAddr),
    .fifoFull     (dirtyFull)
  );

endmodule

// File: tb/tb_dirtyLineTracker.sv
module tb_dirtyLineTracker;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 26;
  localparam int IW = 8;
  localparam int TW = LW - IW;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armValid = 1'b0, shGrant = 1'b0, invValid = 1'b0, dirtyPop = 1'b0;
  logic [LW-1:0] armAddr = '0, invAddr = '0;
  logic armReady, rdShReq, invReady, invAck, dirtyValid, dirtyFull;
  logic [LW-1:0] rdShAddr, dirtyAddr;

  int errors = 0;
  int checks = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirtyLineTracker #(.LINE_W(LW), .INDEX_W(IW), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .armValid(armValid), .armAddr(armAddr), .armReady(armReady),
    .rdShReq(rdShReq), .rdShAddr(rdShAddr), .shGrant(shGrant),
    .invValid(invValid), .invAddr(invAddr), .invReady(invReady), .invAck(invAck),
    .dirtyValid(dirtyValid), .dirtyAddr(dirtyAddr), .dirtyPop(dirtyPop),
    .dirtyFull(dirtyFull)
  );

  // Behavioural reference model
  bit            mValid [256];
  bit [TW-1:0]   mTag   [256];
  bit            mWaiting, mReq, mAck;
  bit [LW-1:0]   mPend;
  bit [LW-1:0]   mQ [$];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mValid[i] = 1'b0;
      mWaiting = 1'b0; mReq = 1'b0; mAck = 1'b0; mPend = '0;
      mQ.delete();
    end else begin
      bit armAcc, armHitM, invAcc, invHitM, popAcc, grantAcc, newReq;
      int ai, ii, pi;
      ai = int'(armAddr[IW-1:0]);
      ii = int'(invAddr[IW-1:0]);
      pi = int'(mPend[IW-1:0]);
      armAcc   = armValid && !mWaiting;
      armHitM  = mValid[ai] && (mTag[ai] == armAddr[LW-1:IW]);
      invAcc   = invValid && (mQ.size() < DEPTH);
      invHitM  = mValid[ii] && (mTag[ii] == invAddr[LW-1:IW]);
      popAcc   = dirtyPop && (mQ.size() > 0);
      grantAcc = shGrant && mWaiting;
      newReq   = armAcc && !armHitM;
      if (popAcc) void'(mQ.pop_front());
      if (invAcc && invHitM) begin
        mValid[ii] = 1'b0;
        mQ.push_back(invAddr);
      end
      if (grantAcc) begin
        mValid[pi] = 1'b1;
        mTag[pi]   = mPend[LW-1:IW];
        mWaiting   = 1'b0;
      end
      if (newReq) begin
        mWaiting = 1'b1;
        mPend    = armAddr;
      end
      mReq = newReq;
      mAck = invAcc;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk("R1", "armReady", 32'(armReady), 32'(!mWaiting));
      chk("R1", "rdShReq", 32'(rdShReq), 32'(mReq));
      if (mReq) chk("R1", "rdShAddr", 32'(rdShAddr), 32'(mPend));
      chk("R7", "invAck", 32'(invAck), 32'(mAck));
      chk("R8", "invReady", 32'(invReady), 32'(mQ.size() < DEPTH));
      chk("R8", "dirtyFull", 32'(dirtyFull), 32'(mQ.size() == DEPTH));
      chk("R3", "dirtyValid", 32'(dirtyValid), 32'(mQ.size() > 0));
      if (mQ.size() > 0) chk("R3", "dirtyAddr", 32'(dirtyAddr), 32'(mQ[0]));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  task automatic armLine(logic [LW-1:0] a);
    while (!armReady) @(negedge clk);
    armValid = 1'b1; armAddr = a;
    @(negedge clk);
    armValid = 1'b0;
  endtask

  task automatic grantNow();
    shGrant = 1'b1;
    @(negedge clk);
    shGrant = 1'b0;
  endtask

  task automatic inval(logic [LW-1:0] a);
    invValid = 1'b1; invAddr = a;
    while (!invReady) @(negedge clk);
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic popExpect(string req, logic [LW-1:0] a);
    chk(req, "head valid", 32'(dirtyValid), 32'd1);
    chk(req, "head addr", 32'(dirtyAddr), 32'(a));
    dirtyPop = 1'b1;
    @(negedge clk);
    dirtyPop = 1'b0;
  endtask

  task automatic trackLine(logic [LW-1:0] a);
    armLine(a);
    grantNow();
  endtask

  initial begin
    logic [LW-1:0] lineA, lineB, lineC, lineD, lineE, lineF;
    lineA = 26'h0001_23; lineB = 26'h0002_45; lineC = 26'h0007_77;
    lineD = 26'h0030_45; lineE = 26'h0004_56; lineF = 26'h0005_9A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "armReady", 32'(armReady), 32'd1);
    chk("R10", "invReady", 32'(invReady), 32'd1);
    chk("R10", "rdShReq", 32'(rdShReq), 32'd0);
    chk("R10", "invAck", 32'(invAck), 32'd0);
    chk("R10", "dirtyValid", 32'(dirtyValid), 32'd0);
    chk("R10", "dirtyFull", 32'(dirtyFull), 32'd0);
    cmpOn = 1'b1;

    // R1: request follows arm
    armLine(lineA);
    chk("R1", "req pulse", 32'(rdShReq), 32'd1);
    chk("R1", "req addr", 32'(rdShAddr), 32'(lineA));
    chk("R1", "busy", 32'(armReady), 32'd0);
    // R2: invalidation before grant yields no record
    inval(lineA);
    chk("R2", "no record before grant", 32'(dirtyValid), 32'd0);
    grantNow();
    // R3: hit records and clears
    inval(lineA);
    chk("R3", "record present", 32'(dirtyValid), 32'd1);
    inval(lineA);
    popExpect("R3", lineA);
    chk("R3", "single record", 32'(dirtyValid), 32'd0);

    // R4: re-arm
    armLine(lineA);
    chk("R4", "new request", 32'(rdShReq), 32'd1);
    grantNow();
    inval(lineA);
    popExpect("R4", lineA);

    // R5: duplicate arm ignored
    trackLine(lineB);
    armLine(lineB);
    chk("R5", "no request", 32'(rdShReq), 32'd0);
    chk("R5", "still ready", 32'(armReady), 32'd1);

    // R6 / R7: miss acknowledged, no record
    inval(lineC);
    chk("R7", "ack on miss", 32'(invAck), 32'd1);
    chk("R6", "no record on miss", 32'(dirtyValid), 32'd0);

    // R9: conflicting slot replaces old tag
    trackLine(lineD);
    inval(lineB);
    chk("R9", "old tag misses", 32'(dirtyValid), 32'd0);
    inval(lineD);
    popExpect("R9", lineD);

    // R11: stray grant ignored
    trackLine(lineE);
    inval(lineE);
    popExpect("R11", lineE);
    grantNow();
    inval(lineE);
    chk("R11", "stray grant no track", 32'(dirtyValid), 32'd0);

    // R12: same-cycle grant and invalidation on the same slot
    armLine(lineF);
    shGrant = 1'b1; invValid = 1'b1; invAddr = lineF;
    @(negedge clk);
    shGrant = 1'b0; invValid = 1'b0;
    chk("R12", "old contents judged", 32'(dirtyValid), 32'd0);
    inval(lineF);
    popExpect("R12", lineF);

    // R8: backpressure and ordering
    for (int k = 0; k < 5; k++) trackLine(LW'(26'h0100_10 + (k << 8) + k));
    for (int k = 0; k < 4; k++) inval(LW'(26'h0100_10 + (k << 8) + k));
    chk("R8", "full", 32'(dirtyFull), 32'd1);
    chk("R8", "not ready", 32'(invReady), 32'd0);
    invValid = 1'b1; invAddr = LW'(26'h0100_10 + (4 << 8) + 4);
    repeat (3) begin
      @(negedge clk);
      chk("R8", "held off", 32'(invAck), 32'd0);
    end
    popExpect("R8", LW'(26'h0100_10));
    while (!invReady) @(negedge clk);
    @(negedge clk);
    invValid = 1'b0;
    for (int k = 1; k < 5; k++) popExpect("R8", LW'(26'h0100_10 + (k << 8) + k));
    chk("R8", "drained", 32'(dirtyValid), 32'd0);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule